// File: doc/BRIEF.md
# SPI Flash Read Command Sequencer

This block runs the host-facing part of a flash-style read once an opcode has been decoded as either a plain array read or a parameter-table read. It collects a 3-byte or 4-byte address from the serial-to-parallel front end, optionally takes one mode byte, waits out a programmable dummy phase, and then paces the payload at one, two or four bits per clock. Each completed payload byte advances the read address and issues a byte-read request for the following byte.

Requests whose address falls inside a programmable mailbox window are flagged so that the memory side can redirect them. A one-cycle buffer-flip pulse marks the end of the last byte in each 1 KiB block. A last-read address register, kept across commands, records the progress of plain reads outside the mailbox.

The sequencing state is cleared asynchronously whenever chip select goes inactive (`cs_rst_n` low). The last-read address register uses the separate system reset.

Top module: `spi_read_sequencer`

## Requirements
- R1: While `phase` is Reset (0), the block leaves it only when `path_sel` is 2'b01 (plain read) or 2'b10 (parameter read). It then goes to Address (1). The values 2'b00 and 2'b11 keep it in Reset.
- R2: In Address, each cycle with `s2p_valid` high shifts `s2p_byte` into `cur_addr`, most significant byte first. Cycles without valid change nothing. The state ends after 4 valid bytes when `addr_4b` is 1 and after 3 valid bytes when it is 0. In 3-byte mode bits 31:24 of the address are zero.
- R3: After the last address byte, {`mbyte_en`,`dummy_en`} selects the next phase. The value 00 goes to Output (4), 01 goes to Dummy (3), and 1x goes to ModeByte (2).
- R4: ModeByte waits for one valid byte and then moves to Dummy. Cycles without valid keep it in ModeByte.
- R5: Dummy lasts `dummy_cycles`+1 clock cycles before the payload phase begins.
- R6: `lanes` 4'b0010 (single), 4'b0011 (dual) and 4'b1111 (quad) give payload bytes of 8, 4 and 2 cycles. Any other value sends the block to Error (5) instead of Output. Error then holds, and `cfg_err` is high while it holds.
- R7: `cur_addr` increments by one at the last cycle of each payload byte, and changes at no other time after the address phase.
- R8: `mem_req` is high in the cycle before Output is entered, carrying the start address. It is also high in the last cycle of every payload byte, carrying that byte's address plus one. The address is given as `mem_word_addr` (bits 31:2) and `mem_byte_sel` (bits 1:0).
- R9: `mem_to_mbx` is high with a request exactly when `mbx_en` and `mbx_intercept` are both set and the request address equals `mbx_base` in all bits above the low MBX_AW (10) bits.
- R10: `buf_flip` pulses in the last cycle of a payload byte whose address has its low 10 bits all ones.
- R11: At the last cycle of a payload byte, `last_addr` takes that byte's address only when all of these hold: the path is a plain read, `flash_mode` is set, and it is not the case that `mbx_en` is set with the address inside the mailbox window. Otherwise `last_addr` keeps its value.
- R12: Driving `cs_rst_n` low returns `phase` to Reset at once, without waiting for a clock edge. `last_addr` is not cleared by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cs_rst_n | input | 1 | Active-low reset, low while chip select is inactive |
| sys_rst_n | input | 1 | Active-low system reset for the last-read address |
| path_sel | input | 2 | Decoded datapath: 01 plain read, 10 parameter read |
| flash_mode | input | 1 | Device is in flash mode |
| s2p_valid | input | 1 | A received byte is present |
| s2p_byte | input | 8 | Received byte |
| addr_4b | input | 1 | Four-byte address mode |
| mbyte_en | input | 1 | Command carries a mode byte |
| dummy_en | input | 1 | Command carries dummy cycles |
| dummy_cycles | input | DUMMY_W | Dummy length minus one |
| lanes | input | 4 | Payload lane encoding |
| mbx_en | input | 1 | Mailbox window enabled |
| mbx_intercept | input | 1 | Redirect reads in the window |
| mbx_base | input | 32 | Mailbox window base |
| phase | output | 3 | Current state code |
| cur_addr | output | 32 | Address of the byte being sent |
| mem_req | output | 1 | Byte-read request |
| mem_word_addr | output | 30 | Request word address |
| mem_byte_sel | output | 2 | Request byte lane |
| mem_to_mbx | output | 1 | Request hits the mailbox |
| buf_flip | output | 1 | 1 KiB boundary pulse |
| last_addr | output | 32 | Last plain-read address |
| cfg_err | output | 1 | Invalid lane configuration |

## Verification
The checker watches, on every cycle, properties that need no knowledge of the command: Reset is left only for a valid path, Error holds once entered, and the address stays put except at a request in Output. It also checks that flip and mailbox flags appear only alongside a request, and that the last-read address moves only at a byte end. Other behaviour depends on the command itself and is shown only by the bench's sweep over lane encodings, address widths, mode/dummy combinations and mailbox settings, using a start address two bytes below a 1 KiB boundary. The sweep covers the exact cycle counts of the address, dummy and payload phases, the request addresses, the point where requests leave the mailbox window, and the conditions that gate the last-read address.

// File: rtl/spi_read_sequencer.sv
module spi_read_sequencer #(
  parameter int DUMMY_W = 3,
  parameter int MBX_AW  = 10,
  parameter int BUF_AW  = 10
) (
  input  logic               clk,
  input  logic               cs_rst_n,
  input  logic               sys_rst_n,
  input  logic [1:0]         path_sel,
  input  logic               flash_mode,
  input  logic               s2p_valid,
  input  logic [7:0]         s2p_byte,
  input  logic               addr_4b,
  input  logic               mbyte_en,
  input  logic               dummy_en,
  input  logic [DUMMY_W-1:0] dummy_cycles,
  input  logic [3:0]         lanes,
  input  logic               mbx_en,
  input  logic               mbx_intercept,
  input  logic [31:0]        mbx_base,
  output logic [2:0]         phase,
  output logic [31:0]        cur_addr,
  output logic               mem_req,
  output logic [29:0]        mem_word_addr,
  output logic [1:0]         mem_byte_sel,
  output logic               mem_to_mbx,
  output logic               buf_flip,
  output logic [31:0]        last_addr,
  output logic               cfg_err
);

  localparam logic [1:0]  PATH_READ  = 2'b01;
  localparam logic [1:0]  PATH_PARAM = 2'b10;
  localparam logic [31:0] MBX_MASK   = ~((32'd1 << MBX_AW) - 32'd1);

  typedef enum logic [2:0] {
    S_RESET = 3'd0, S_ADDR = 3'd1, S_MODE = 3'd2,
    S_DUMMY = 3'd3, S_OUT  = 3'd4, S_ERR  = 3'd5
  } state_e;

  state_e st, nxt;
  logic [4:0]         acnt;
  logic [DUMMY_W-1:0] dcnt;
  logic [2:0]         bcnt, reload;
  logic               lane_ok, byte_end, go_out, addr_last;
  logic [31:0]        req_addr;

  always_comb begin
    lane_ok = 1'b1;
    case (lanes)
      4'b0010: reload = 3'd7;
      4'b0011: reload = 3'd3;
      4'b1111: reload = 3'd1;
      default: begin reload = 3'd7; lane_ok = 1'b0; end
    endcase
  end

  assign addr_last = s2p_valid && (acnt == 5'd7);
  assign byte_end  = (st == S_OUT) && (bcnt == 3'd0);

  always_comb begin
    nxt = st;
    case (st)
      S_RESET: if (path_sel == PATH_READ || path_sel == PATH_PARAM) nxt = S_ADDR;
      S_ADDR:
        if (addr_last) begin
          casez ({mbyte_en, dummy_en})
            2'b00:   nxt = lane_ok ? S_OUT : S_ERR;
            2'b01:   nxt = S_DUMMY;
            2'b1?:   nxt = S_MODE;
            default: nxt = S_ERR;
          endcase
        end
      S_MODE:  if (s2p_valid) nxt = S_DUMMY;
      S_DUMMY: if (dcnt == '0) nxt = lane_ok ? S_OUT : S_ERR;
      S_OUT:   nxt = S_OUT;
      default: nxt = S_ERR;
    endcase
  end

  always_ff @(posedge clk or negedge cs_rst_n) begin
    if (!cs_rst_n) begin
      st       <= S_RESET;
      acnt     <= '0;
      dcnt     <= '0;
      bcnt     <= '0;
      cur_addr <= '0;
    end else begin
      st <= nxt;
      if (st == S_RESET && nxt == S_ADDR) begin
        acnt     <= addr_4b ? 5'd31 : 5'd23;
        cur_addr <= '0;
      end
      if (st == S_ADDR && s2p_valid) begin
        cur_addr <= {cur_addr[23:0], s2p_byte};
        if (!addr_last) acnt <= acnt - 5'd8;
      end
      if (nxt == S_DUMMY && st != S_DUMMY) dcnt <= dummy_cycles;
      else if (st == S_DUMMY && dcnt != '0) dcnt <= dcnt - 1'b1;
      if (go_out) bcnt <= reload;
      else if (st == S_OUT) begin
        if (bcnt == 3'd0) begin
          bcnt     <= reload;
          cur_addr <= cur_addr + 32'd1;
        end else begin
          bcnt <= bcnt - 3'd1;
        end
      end
    end
  end

  assign go_out        = (st != S_OUT) && (nxt == S_OUT);
  assign req_addr      = (st == S_ADDR) ? {cur_addr[23:0], s2p_byte}
                       : (go_out ? cur_addr : cur_addr + 32'd1);
  assign mem_req       = go_out || byte_end;
  assign mem_word_addr = req_addr[31:2];
  assign mem_byte_sel  = req_addr[1:0];
  assign mem_to_mbx    = mem_req && mbx_en && mbx_intercept &&
                         ((req_addr & MBX_MASK) == (mbx_base & MBX_MASK));
  assign buf_flip      = byte_end && (&cur_addr[BUF_AW-1:0]);
  assign phase         = st;
  assign cfg_err       = (st == S_ERR);

  logic cur_in_mbx;
  assign cur_in_mbx = ((cur_addr & MBX_MASK) == (mbx_base & MBX_MASK));

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) last_addr <= '0;
    else if (byte_end && path_sel == PATH_READ && flash_mode && !(mbx_en && cur_in_mbx))
      last_addr <= cur_addr;
  end

endmodule

// File: rtl/spi_read_sequencer_chk.sv
module spi_read_sequencer_chk (
  input logic        clk,
  input logic        cs_rst_n,
  input logic        sys_rst_n,
  input logic [1:0]  path_sel,
  input logic [2:0]  phase,
  input logic [31:0] cur_addr,
  input logic        mem_req,
  input logic        mem_to_mbx,
  input logic        buf_flip,
  input logic        mbx_en,
  input logic        mbx_intercept,
  input logic [31:0] last_addr
);

  p_reset_exit_r1: assert property (@(posedge clk) disable iff (!cs_rst_n)
    (phase == 3'd0 && !(path_sel == 2'b01 || path_sel == 2'b10)) |=> phase == 3'd0);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!cs_rst_n)
    (phase == 3'd5) |=> phase == 3'd5);

  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!cs_rst_n)
    ((phase == 3'd4 && !mem_req) || phase == 3'd2 || phase == 3'd3) |=> $stable(cur_addr));

  p_mbx_gate_r9: assert property (@(posedge clk) disable iff (!cs_rst_n)
    mem_to_mbx |-> (mem_req && mbx_en && mbx_intercept));

  p_flip_at_req_r10: assert property (@(posedge clk) disable iff (!cs_rst_n)
    buf_flip |-> (mem_req && phase == 3'd4));

  p_last_hold_r11: assert property (@(posedge clk) disable iff (!sys_rst_n || !cs_rst_n)
    !(phase == 3'd4 && mem_req) |=> $stable(last_addr));

endmodule

bind spi_read_sequencer spi_read_sequencer_chk i_chk (
  .clk(clk), .cs_rst_n(cs_rst_n), .sys_rst_n(sys_rst_n), .path_sel(path_sel),
  .phase(phase), .cur_addr(cur_addr), .mem_req(mem_req), .mem_to_mbx(mem_to_mbx),
  .buf_flip(buf_flip), .mbx_en(mbx_en), .mbx_intercept(mbx_intercept),
  .last_addr(last_addr)
);

// File: tb/test_spi_read_sequencer.sv
module test_spi_read_sequencer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        cs_rst_n, sys_rst_n;
  logic [1:0]  path_sel;
  logic        flash_mode, s2p_valid;
  logic [7:0]  s2p_byte;
  logic        addr_4b, mbyte_en, dummy_en;
  logic [2:0]  dummy_cycles;
  logic [3:0]  lanes;
  logic        mbx_en, mbx_intercept;
  logic [31:0] mbx_base;
  logic [2:0]  phase;
  logic [31:0] cur_addr, last_addr;
  logic        mem_req, mem_to_mbx, buf_flip, cfg_err;
  logic [29:0] mem_word_addr;
  logic [1:0]  mem_byte_sel;

  int n_chk = 0;
  int n_fail = 0;

  spi_read_sequencer i_spi_read_sequencer (
    .clk(clk), .cs_rst_n(cs_rst_n), .sys_rst_n(sys_rst_n), .path_sel(path_sel),
    .flash_mode(flash_mode), .s2p_valid(s2p_valid), .s2p_byte(s2p_byte),
    .addr_4b(addr_4b), .mbyte_en(mbyte_en), .dummy_en(dummy_en),
    .dummy_cycles(dummy_cycles), .lanes(lanes), .mbx_en(mbx_en),
    .mbx_intercept(mbx_intercept), .mbx_base(mbx_base), .phase(phase),
    .cur_addr(cur_addr), .mem_req(mem_req), .mem_word_addr(mem_word_addr),
    .mem_byte_sel(mem_byte_sel), .mem_to_mbx(mem_to_mbx), .buf_flip(buf_flip),
    .last_addr(last_addr), .cfg_err(cfg_err)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit in_win(input logic [31:0] a, input logic [31:0] b);
    return (a & ~32'h3FF) == (b & ~32'h3FF);
  endfunction

  task automatic check_req(input string tag, input logic [31:0] a, input bit en, input bit ic,
                           input logic [31:0] base);
    check({tag, " req"}, {31'd0, mem_req}, 32'd1);
    check({tag, " word"}, {2'b0, mem_word_addr}, {2'b0, a[31:2]});
    check({tag, " lane"}, {30'd0, mem_byte_sel}, {30'd0, a[1:0]});
    check("R9 mbx", {31'd0, mem_to_mbx}, {31'd0, en && ic && in_win(a, base)});
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] last_exp;
    cs_rst_n = 0; sys_rst_n = 0; path_sel = 0; flash_mode = 0; s2p_valid = 0;
    s2p_byte = 0; addr_4b = 0; mbyte_en = 0; dummy_en = 0; dummy_cycles = 0;
    lanes = 4'b0010; mbx_en = 0; mbx_intercept = 0; mbx_base = 0;
    last_exp = 0;
    repeat (2) @(negedge clk);
    sys_rst_n = 1;
    #1;
    check("R12 reset phase", {29'd0, phase}, 0);
    check("R11 reset last", last_addr, 0);

    cs_rst_n = 1; path_sel = 2'b00;
    step(); check("R1 sel00", {29'd0, phase}, 0);
    step(); check("R1 sel00", {29'd0, phase}, 0);
    path_sel = 2'b11;
    step(); check("R1 sel11", {29'd0, phase}, 0);
    cs_rst_n = 0;
    @(negedge clk);

    for (int idx = 0; idx < 64; idx++) begin
      logic [7:0]  b [4];
      logic [31:0] a;
      int nb, blen, dly, ok;
      logic [1:0] mm;
      logic [3:0] lv;
      bit param, en, ic, fm;
      case (idx[1:0])
        2'd0: begin lv = 4'b0010; blen = 8; end
        2'd1: begin lv = 4'b0011; blen = 4; end
        2'd2: begin lv = 4'b1111; blen = 2; end
        default: begin lv = 4'b0101; blen = 0; end
      endcase
      ok = (blen != 0);
      nb = idx[2] ? 4 : 3;
      mm = idx[4:3];
      dly = idx[5] ? 3 : 0;
      en = idx[0] ^ idx[2];
      ic = idx[1] ^ idx[5];
      param = idx[3] ^ idx[5];
      fm = !(idx[4] && idx[0]);
      b[0] = 8'h10 + 8'(idx); b[1] = 8'h47; b[2] = 8'h2B; b[3] = 8'hFE;
      if (nb == 3) begin b[0] = 8'h47 + 8'(idx); b[1] = 8'h2B; b[2] = 8'hFE; end
      a = 0;
      for (int i = 0; i < nb; i++) a = {a[23:0], b[i]};

      lanes = lv; addr_4b = idx[2]; mbyte_en = mm[1]; dummy_en = mm[0];
      dummy_cycles = 3'(dly); mbx_en = en; mbx_intercept = ic; mbx_base = a & ~32'h3FF;
      path_sel = param ? 2'b10 : 2'b01; flash_mode = fm;
      cs_rst_n = 1;
      #1;
      check("R1 idle", {29'd0, phase}, 0);
      step();
      check("R1 to addr", {29'd0, phase}, 1);
      s2p_valid = 0;
      step();
      check("R2 no valid", {29'd0, phase}, 1);
      for (int i = 0; i < nb; i++) begin
        s2p_valid = 1; s2p_byte = b[i];
        #1;
        if (i == nb - 1 && mm == 2'b00 && ok) check_req("R8 entry", a, en, ic, mbx_base);
        else check("R8 no req", {31'd0, mem_req}, 0);
        step();
      end
      s2p_valid = 0;
      check("R2 addr", cur_addr, a);
      if (mm == 2'b00) check("R3 next", {29'd0, phase}, ok ? 4 : 5);
      else if (mm == 2'b01) check("R3 next", {29'd0, phase}, 3);
      else begin
        check("R3 next", {29'd0, phase}, 2);
        step();
        check("R4 wait", {29'd0, phase}, 2);
        s2p_valid = 1; s2p_byte = 8'hA5;
        step();
        s2p_valid = 0;
        check("R4 to dummy", {29'd0, phase}, 3);
      end
      if (mm != 2'b00) begin
        for (int j = 0; j <= dly; j++) begin
          #1;
          check("R5 dummy", {29'd0, phase}, 3);
          if (j == dly && ok) check_req("R8 entry", a, en, ic, mbx_base);
          else check("R8 no req", {31'd0, mem_req}, 0);
          step();
        end
        check("R5 end", {29'd0, phase}, ok ? 4 : 5);
      end
      if (!ok) begin
        check("R6 err flag", {31'd0, cfg_err}, 1);
        step();
        check("R6 err hold", {29'd0, phase}, 5);
      end else begin
        check("R6 no err", {31'd0, cfg_err}, 0);
        for (int k = 0; k < 3 * blen; k++) begin
          int bi, pos;
          logic [31:0] ca;
          bi = k / blen; pos = k % blen; ca = a + 32'(bi);
          check("R6 out", {29'd0, phase}, 4);
          check("R7 addr", cur_addr, ca);
          if (pos == blen - 1) begin
            check_req("R8 next", ca + 1, en, ic, mbx_base);
            check("R10 flip", {31'd0, buf_flip}, {31'd0, ca[9:0] == 10'h3FF});
            if (!param && fm && !(en && in_win(ca, mbx_base))) last_exp = ca;
          end else begin
            check("R8 idle", {31'd0, mem_req}, 0);
            check("R10 no flip", {31'd0, buf_flip}, 0);
          end
          step();
        end
        check("R11 last", last_addr, last_exp);
      end
      cs_rst_n = 0;
      #1;
      check("R12 async", {29'd0, phase}, 0);
      check("R12 keep last", last_addr, last_exp);
      @(negedge clk);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule